// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a hardware master for the serial management channel that sits beside an Ethernet MII. From a system clock it makes the management clock (MDC) with a programmable half-period divider. It drives, releases and samples the bidirectional data line (MDIO) through a separate output value, output enable and input sample. A one-cycle `start` pulse launches one frame. The frame carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data.

Every frame opens with a full preamble of ones. The header follows, and then either a driven write payload or a released line from which the PHY answers. On a read, the PHY must pull the turnaround bit low. If it does not, the block treats the PHY as absent. It keeps clocking the line for a recovery stretch, returns all ones and raises an error flag. `busy` covers the whole frame and a single-cycle `done` pulse closes it.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is active, `mdc` is low, `mdio_oe` is low, `busy` and `done` are low. Reset clears `rd_data` and `absent_err` to zero.
- R2: Each frame starts with 32 MDC cycles in which MDIO is driven to 1, with no option to skip them.
- R3: After the preamble, the bits in MDC cycles 32..45 (counted from 0) are: start pattern 0,1; opcode 1,0 for a read (`rd_nwr`=1) or 0,1 for a write; `phy_addr` MSB first; then `reg_addr` MSB first.
- R4: MDIO value and enable change only while MDC is low. They hold steady from each rising MDC edge through the whole high phase.
- R5: A write drives turnaround 1,0 in cycles 46..47 and `wr_data` MSB first in cycles 48..63. It releases MDIO for cycle 64 and ends after exactly 65 MDC cycles.
- R6: A read releases MDIO from cycle 46 on and samples MDIO at each rising MDC edge. When cycle 46 reads 0, cycles 47..62 are shifted into `rd_data` MSB first. Two trailing MDC cycles follow, for 65 cycles in all, and `absent_err` is 0.
- R7: When the read turnaround sample in cycle 46 is 1, the block gives 32 more released MDC cycles (79 in all). It then ends with `rd_data` = 0xFFFF and `absent_err` = 1.
- R8: Each MDC phase, low and high, lasts `HALF_DIV` system clocks, so rising edges are `2*HALF_DIV` clocks apart.
- R9: A `start` pulse while `busy` is high is ignored: the running frame's bits, length and single `done` are unchanged.
- R10: `busy` rises the cycle after an accepted `start` and falls in the cycle where the one-cycle `done` pulse is high. A `start` given during that `done` cycle is accepted.
- R11: `absent_err` and `rd_data` are updated only when `done` rises. A write clears `absent_err` and leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one frame (ignored while busy) |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write payload |
| mdio_i | input | 1 | Sampled MDIO line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rd_data | output | 16 | Read result (0xFFFF when PHY absent) |
| absent_err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The completion pulse of one frame and the acceptance of the next `start` can fall in the same system cycle. The bench provokes this by raising `start` at the very sample where it first sees `done`. It then judges the chained frame on its full bit sequence, its length and its single `done`, just as it judges an isolated frame. A second overlap is a `start` arriving in mid-frame. The bench injects one with different fields and requires the running frame to come out bit-for-bit as expected.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Fixed fields of a clause-22 management frame
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic cyc_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // rise: edge where MDC goes high; cyc_end: edge where MDC goes low
  assign rise    = run && last && !mdc;
  assign cyc_end = run && last && mdc;
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b1};
  end

  assign bit_out = sr[W-1];
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          sample,
  input  logic          bit_in,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (sample)  word <= {word[DW-2:0], bit_in};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV    = 4,
  parameter int PRE_LEN     = 32,
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int RECOVER_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd_nwr,
  input  logic [AW-1:0] phy_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          mdio_i,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          absent_err,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe
);
  import mdio_pkg::*;

  localparam int HDR_CYC     = PRE_LEN + 4 + 2 * AW;
  localparam int TA_CYC      = HDR_CYC;
  localparam int WR_DRIVE    = HDR_CYC + 2 + DW;
  localparam int WR_LAST     = WR_DRIVE + 1;
  localparam int RD_OK_LAST  = HDR_CYC + 1 + DW + 2;
  localparam int RD_ABS_LAST = HDR_CYC + 1 + RECOVER_LEN;
  localparam int MAX_A       = (WR_LAST > RD_OK_LAST) ? WR_LAST : RD_OK_LAST;
  localparam int MAX_LAST    = (MAX_A > RD_ABS_LAST) ? MAX_A : RD_ABS_LAST;
  localparam int CYC_W       = $clog2(MAX_LAST + 1);
  localparam int TXW         = HDR_CYC + 2 + DW;

  logic             active, is_rd, absent;
  logic [CYC_W-1:0] cyc, cyc_nxt, drive_len, last_len;
  logic             rise, cyc_end, accept, rx_sample;
  logic [TXW-1:0]   tx_frame;
  logic [DW-1:0]    rx_word;

  assign accept  = start && !active;
  assign cyc_nxt = cyc + CYC_W'(1);

  assign drive_len = is_rd ? CYC_W'(HDR_CYC) : CYC_W'(WR_DRIVE);
  assign last_len  = !is_rd ? CYC_W'(WR_LAST)
                   : (absent ? CYC_W'(RD_ABS_LAST) : CYC_W'(RD_OK_LAST));

  assign tx_frame = {{PRE_LEN{1'b1}}, START_PAT, (rd_nwr ? OP_READ : OP_WRITE),
                     phy_addr, reg_addr, TA_WRITE, wr_data};

  assign rx_sample = active && rise && is_rd && !absent &&
                     (cyc > CYC_W'(TA_CYC)) && (cyc <= CYC_W'(TA_CYC + DW));

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(active),
    .mdc(mdc), .rise(rise), .cyc_end(cyc_end)
  );

  mdio_tx_shift #(.W(TXW)) u_tx (
    .clk(clk), .rst(rst), .load(accept), .load_val(tx_frame),
    .shift(active && cyc_end), .bit_out(mdio_o)
  );

  mdio_rx_capture #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .clear(accept), .sample(rx_sample),
    .bit_in(mdio_i), .word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      is_rd      <= 1'b0;
      absent     <= 1'b0;
      cyc        <= '0;
      mdio_oe    <= 1'b0;
      done       <= 1'b0;
      rd_data    <= '0;
      absent_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          is_rd   <= rd_nwr;
          absent  <= 1'b0;
          cyc     <= '0;
          mdio_oe <= 1'b1;
        end
      end else begin
        if (rise && is_rd && (cyc == CYC_W'(TA_CYC)) && mdio_i)
          absent <= 1'b1;
        if (cyc_end) begin
          cyc <= cyc_nxt;
          if (cyc_nxt == drive_len)
            mdio_oe <= 1'b0;
          if (cyc_nxt == last_len) begin
            active     <= 1'b0;
            done       <= 1'b1;
            absent_err <= is_rd && absent;
            if (is_rd)
              rd_data <= absent ? {DW{1'b1}} : rx_word;
          end
        end
      end
    end
  end

  assign busy = active;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rd_data,
  input logic          absent_err,
  input logic          mdc,
  input logic          mdio_o,
  input logic          mdio_oe
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_absent_all_ones: assert property (@(posedge clk) disable iff (rst)
    (done && absent_err) |-> (rd_data == {DW{1'b1}}));

  a_r11_err_only_at_done: assert property (@(posedge clk) disable iff (rst)
    (!done) |-> $stable(absent_err));
endmodule

bind mdio_master mdio_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .rd_data(rd_data),
  .absent_err(absent_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_nwr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        mdio_i = 1'b1;
  logic        busy, done, absent_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  mdio_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .mdio_i(mdio_i), .busy(busy), .done(done), .rd_data(rd_data),
    .absent_err(absent_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // PHY model state (written by stimulus only)
  bit          phy_present = 1'b1;
  logic [15:0] phy_word = '0;
  int          fbase = 0;

  // monitor state (written by monitor only)
  int   gr = 0;
  int   ccount = 0;
  int   hold_err = 0;
  logic prev_mdc = 1'b0;
  logic rec_o  [0:255];
  logic rec_oe [0:255];
  int   rec_t  [0:255];

  function automatic logic phy_bit(int k);
    if (!phy_present) return 1'b1;
    if (k == 46) return 1'b0;
    if (k >= 47 && k <= 62) return phy_word[15 - (k - 47)];
    return 1'b1;
  endfunction

  function automatic logic exp_bit(logic rd, logic [4:0] pa, logic [4:0] ra,
                                   logic [15:0] wd, int k);
    if (k < 32) return 1'b1;
    if (k == 32) return 1'b0;
    if (k == 33) return 1'b1;
    if (k == 34) return rd;
    if (k == 35) return !rd;
    if (k <= 40) return pa[4 - (k - 36)];
    if (k <= 45) return ra[4 - (k - 41)];
    if (k == 46) return 1'b1;
    if (k == 47) return 1'b0;
    return wd[15 - (k - 48)];
  endfunction

  always @(negedge clk) begin
    ccount <= ccount + 1;
    if (rst) begin
      prev_mdc <= 1'b0;
      mdio_i   <= 1'b1;
    end else begin
      prev_mdc <= mdc;
      if (mdc && !prev_mdc) begin
        rec_o[gr % 256]  <= mdio_o;
        rec_oe[gr % 256] <= mdio_oe;
        rec_t[gr % 256]  <= ccount;
        gr <= gr + 1;
      end else if (mdc && prev_mdc) begin
        if (mdio_o !== rec_o[(gr - 1) % 256] || mdio_oe !== rec_oe[(gr - 1) % 256])
          hold_err <= hold_err + 1;
      end else if (!mdc && prev_mdc) begin
        mdio_i <= phy_bit(gr - fbase);
      end
    end
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_frame(logic rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                           bit present, logic [15:0] word, bit inject, bit chain);
    int exp_rises, drv, k, bad, ndone, herr0, b;
    logic [15:0] rd_before;
    logic        busy_seen;
    phy_present = present;
    phy_word    = word;
    fbase       = gr;
    herr0       = hold_err;
    rd_before   = rd_data;
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    check(busy_seen === 1'b1, "R10", "busy after start", busy_seen, 1);
    k = 0; ndone = 0;
    while (ndone == 0 && k < 2000) begin
      @(negedge clk);
      k++;
      if (inject && k == 20) begin
        start = 1'b1; rd_nwr = !rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
      end else if (inject && k == 21) begin
        start = 1'b0;
      end
      if (done) ndone++;
    end
    check(ndone == 1, "R10", "done seen", ndone, 1);
    check(busy === 1'b0, "R10", "busy low in done cycle", busy, 0);
    exp_rises = rd ? (present ? 65 : 79) : 65;
    drv = rd ? 46 : 64;
    check(gr - fbase == exp_rises, rd ? (present ? "R6" : "R7") : "R5",
          "MDC cycle count", gr - fbase, exp_rises);
    bad = 0;
    for (int i = 0; i < 32; i++)
      if (rec_oe[(fbase + i) % 256] !== 1'b1 || rec_o[(fbase + i) % 256] !== 1'b1) bad++;
    check(bad == 0, "R2", "preamble bit errors", bad, 0);
    bad = 0;
    for (int i = 32; i < 46; i++)
      if (rec_oe[(fbase + i) % 256] !== 1'b1 ||
          rec_o[(fbase + i) % 256] !== exp_bit(rd, pa, ra, wd, i)) bad++;
    check(bad == 0, "R3", "header bit errors", bad, 0);
    if (!rd) begin
      bad = 0;
      for (int i = 46; i < 64; i++)
        if (rec_oe[(fbase + i) % 256] !== 1'b1 ||
            rec_o[(fbase + i) % 256] !== exp_bit(rd, pa, ra, wd, i)) bad++;
      check(bad == 0, "R5", "turnaround/data bit errors", bad, 0);
    end
    bad = 0;
    for (int i = drv; i < exp_rises; i++)
      if (rec_oe[(fbase + i) % 256] !== 1'b0) bad++;
    check(bad == 0, rd ? "R6" : "R5", "released cycles driven", bad, 0);
    check(hold_err == herr0, "R4", "MDIO change while MDC high", hold_err - herr0, 0);
    b = rec_t[(fbase + 1) % 256] - rec_t[fbase % 256];
    check(b == 2 * HALF, "R8", "MDC period in clocks", b, 2 * HALF);
    if (rd) begin
      check(rd_data === (present ? word : 16'hFFFF), present ? "R6" : "R7",
            "read data", rd_data, present ? word : 16'hFFFF);
      check(absent_err === !present, present ? "R6" : "R7", "absent flag", absent_err, !present);
    end else begin
      check(rd_data === rd_before, "R11", "rd_data kept on write", rd_data, rd_before);
      check(absent_err === 1'b0, "R11", "flag cleared by write", absent_err, 0);
    end
    if (inject)
      check(bad == 0 && ndone == 1 && gr - fbase == exp_rises, "R9",
            "mid-frame start ignored", gr - fbase, exp_rises);
    if (!chain) begin
      b = gr;
      bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (done || busy || mdc || mdio_oe) bad++;
      end
      check(bad == 0 && gr == b, "R1", "idle after frame", bad, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !mdc && !mdio_oe, "R1", "idle outputs after reset",
          {busy, done, mdc, mdio_oe}, 0);
    check(rd_data === 16'h0 && absent_err === 1'b0, "R1", "reset results", rd_data, 0);
    // directed corner cases
    run_frame(1'b0, 5'h1F, 5'h00, 16'hA5C3, 1'b1, 16'h0, 1'b0, 1'b0);
    run_frame(1'b1, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'h8001, 1'b0, 1'b0);
    run_frame(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0);
    run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 1'b1, 16'h0, 1'b1, 1'b0);   // R9 inject
    run_frame(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0);
    run_frame(1'b1, 5'h11, 5'h03, 16'h0000, 1'b1, 16'hFFFE, 1'b1, 1'b0); // R11 clears flag
    // R10: next start in the done cycle
    run_frame(1'b0, 5'h05, 5'h06, 16'h1234, 1'b1, 16'h0, 1'b0, 1'b1);
    run_frame(1'b1, 5'h07, 5'h08, 16'h0000, 1'b1, 16'h5A5A, 1'b0, 1'b1);
    run_frame(1'b1, 5'h09, 5'h0B, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0);
    // constrained random frames
    for (int n = 0; n < 14; n++) begin
      logic rd;
      bit   pres;
      rd   = 1'($urandom);
      pres = ($urandom % 4) != 0;
      run_frame(rd, 5'($urandom), 5'($urandom), 16'($urandom), pres, 16'($urandom),
                ($urandom % 5) == 0, ($urandom % 3) == 0);
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule